// File: doc/BRIEF.md
# Double-Buffered Overlay Window Register Bank

This block holds the placement and enable settings of five overlay windows for a display scan-out engine. Each window has two copies of its settings. Software writes the pending copy through a plain address/data port. The scan-out side sees only the active copy. On every vertical sync pulse, the pending copy of each window is moved into its active copy, unless that window is currently protected.

The protect bits let software change several registers of one window and have them take effect together on a single frame. Software sets the window's protect bit, rewrites the window's registers, and then clears the bit. The new settings become visible at the first vertical sync after the bit is cleared. The active side also gives, for each window, the inclusive bottom-right corner and, for the windows that have one, the pixel area. Both are derived from the origin and the extent.

Top module: `wincfg_bank`

## Requirements
- R1: After synchronous reset, every active output is 0. Every pending register and the protect register read back 0.
- R2: A write changes only the pending copy. It reads back from the cycle after the write. The active outputs keep their values until a vsync pulse is seen.
- R3: The active outputs show the pending values from the cycle after a vsync pulse, for every unprotected window.
- R4: A window whose protect bit is set keeps its active values across vsync. Once the bit is cleared, the next vsync copies all of that window's pending values at once.
- R5: Clearing a window's enable bit leaves that window's active enable at 1 until the next vsync.
- R6: The bottom-right x equals x + width − 1, and the bottom-right y equals y + height − 1. When the sum is 0, the result is 0.
- R7: The area output equals width × height for windows 0, 1 and 2. For windows 3 and 4 the area output is always 0.
- R8: When a write and a vsync pulse occur in the same cycle, the active copy takes the pending value from before the write. The written value reaches the active copy at a later vsync.
- R9: Address map:
  - Window n occupies the 16-byte group that starts at 16·n.
  - Group offset 0x0: enable in bit 0.
  - Group offset 0x4: origin, with x in bits 10:0 and y in bits 26:16.
  - Group offset 0x8: extent, with width in bits 10:0 and height in bits 26:16.
  - Address 0x50 holds the protect bits, bit n for window n.
  - Reading any other address returns 0.
- R10: The protect register is not double-buffered. It reads back the written value in the next cycle, and it applies to a vsync in any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | One-cycle vertical sync pulse |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | 8 | Byte address for writes and reads |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the pending copy at cfg_addr, combinational |
| act_en | output | 5 | Active enable per window |
| act_tl_x | output | 55 | Active origin x, 11 bits per window |
| act_tl_y | output | 55 | Active origin y, 11 bits per window |
| act_br_x | output | 55 | Active inclusive bottom-right x, 11 bits per window |
| act_br_y | output | 55 | Active inclusive bottom-right y, 11 bits per window |
| act_area | output | 110 | Active width × height, 22 bits per window |

## Verification
A corrupted pending copy shows up on cfg_rdata in the cycle right after the write, well before any frame boundary. A fault in the transfer path shows up on the active outputs one cycle after the vsync pulse. In that case a window either changes with no vsync, fails to change at vsync, or changes while protected. The bench compares all five windows on every step, so a shadow-load fault that reaches the wrong window is also caught within one cycle.

// File: rtl/wincfg_pkg.sv
package wincfg_pkg;
    parameter int NUM_WIN = 5;
    parameter int CW      = 11;
    parameter int AW      = 2 * CW;
    parameter int ADDR_W  = 8;
    parameter int DATA_W  = 32;

    localparam int GRP_W     = ADDR_W - 4;
    localparam int Y_LSB     = 16;
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_ORIG = 4'h4;
    localparam logic [3:0] OFS_EXT  = 4'h8;
    localparam logic [ADDR_W-1:0] PROT_ADDR = 8'h50;
    localparam logic [NUM_WIN-1:0] SIZE_MASK = 5'b00111;

    typedef struct packed {
        logic          en;
        logic [CW-1:0] x;
        logic [CW-1:0] y;
        logic [CW-1:0] w;
        logic [CW-1:0] h;
    } win_cfg_t;

    function automatic logic [CW-1:0] last_pix(input logic [CW-1:0] start,
                                               input logic [CW-1:0] len);
        logic [CW:0] sum;
        logic [CW:0] dec;
        sum = {1'b0, start} + {1'b0, len};
        dec = sum - 1'b1;
        return (sum == '0) ? '0 : dec[CW-1:0];
    endfunction
endpackage

// File: rtl/win_slot.sv
module win_slot
    import wincfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vsync,
    input  logic              prot,
    input  logic              wr_ctrl,
    input  logic              wr_orig,
    input  logic              wr_ext,
    input  logic [DATA_W-1:0] wdata,
    output win_cfg_t          pend,
    output win_cfg_t          act
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            act  <= '0;
        end else begin
            if (vsync && !prot) act <= pend;
            if (wr_ctrl) pend.en <= wdata[0];
            if (wr_orig) begin
                pend.x <= wdata[CW-1:0];
                pend.y <= wdata[Y_LSB +: CW];
            end
            if (wr_ext) begin
                pend.w <= wdata[CW-1:0];
                pend.h <= wdata[Y_LSB +: CW];
            end
        end
    end

    // R2
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(vsync)) |-> $stable(act));
    // R4
    prot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(vsync) && $past(prot)) |-> $stable(act));
    // R3
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(vsync) && !$past(prot)) |-> (act == $past(pend)));
endmodule

// File: rtl/win_geom.sv
module win_geom
    import wincfg_pkg::*;
#(
    parameter bit HAS_SIZE = 1'b1
) (
    input  win_cfg_t      act,
    output logic          en,
    output logic [CW-1:0] tl_x,
    output logic [CW-1:0] tl_y,
    output logic [CW-1:0] br_x,
    output logic [CW-1:0] br_y,
    output logic [AW-1:0] area
);
    assign en   = act.en;
    assign tl_x = act.x;
    assign tl_y = act.y;
    assign br_x = last_pix(act.x, act.w);
    assign br_y = last_pix(act.y, act.h);

    generate
        if (HAS_SIZE) begin : g_area
            assign area = {{(AW-CW){1'b0}}, act.w} * {{(AW-CW){1'b0}}, act.h};
        end else begin : g_noarea
            assign area = '0;
        end
    endgenerate
endmodule

// File: rtl/wincfg_bank.sv
module wincfg_bank
    import wincfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  vsync,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output logic [DATA_W-1:0]     cfg_rdata,
    output logic [NUM_WIN-1:0]    act_en,
    output logic [NUM_WIN*CW-1:0] act_tl_x,
    output logic [NUM_WIN*CW-1:0] act_tl_y,
    output logic [NUM_WIN*CW-1:0] act_br_x,
    output logic [NUM_WIN*CW-1:0] act_br_y,
    output logic [NUM_WIN*AW-1:0] act_area
);
    logic [NUM_WIN-1:0] prot_q;
    win_cfg_t           pend [NUM_WIN];
    win_cfg_t           act  [NUM_WIN];
    logic [GRP_W-1:0]   grp;
    logic [3:0]         ofs;
    logic               unused_wdata;

    assign grp = cfg_addr[ADDR_W-1:4];
    assign ofs = cfg_addr[3:0];
    assign unused_wdata = ^{cfg_wdata[DATA_W-1:Y_LSB+CW], cfg_wdata[Y_LSB-1:CW]};

    always_ff @(posedge clk) begin
        if (rst) prot_q <= '0;
        else if (cfg_we && cfg_addr == PROT_ADDR) prot_q <= cfg_wdata[NUM_WIN-1:0];
    end

    generate
        for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
            logic hit;
            assign hit = cfg_we && (grp == GRP_W'(i));

            win_slot u_slot (
                .clk     (clk),
                .rst     (rst),
                .vsync   (vsync),
                .prot    (prot_q[i]),
                .wr_ctrl (hit && ofs == OFS_CTRL),
                .wr_orig (hit && ofs == OFS_ORIG),
                .wr_ext  (hit && ofs == OFS_EXT),
                .wdata   (cfg_wdata),
                .pend    (pend[i]),
                .act     (act[i])
            );

            win_geom #(.HAS_SIZE(SIZE_MASK[i])) u_geom (
                .act  (act[i]),
                .en   (act_en[i]),
                .tl_x (act_tl_x[i*CW +: CW]),
                .tl_y (act_tl_y[i*CW +: CW]),
                .br_x (act_br_x[i*CW +: CW]),
                .br_y (act_br_y[i*CW +: CW]),
                .area (act_area[i*AW +: AW])
            );
        end
    endgenerate

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == PROT_ADDR) begin
            cfg_rdata[NUM_WIN-1:0] = prot_q;
        end else begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (grp == GRP_W'(i)) begin
                    case (ofs)
                        OFS_CTRL: cfg_rdata[0] = pend[i].en;
                        OFS_ORIG: begin
                            cfg_rdata[CW-1:0]      = pend[i].x;
                            cfg_rdata[Y_LSB +: CW] = pend[i].y;
                        end
                        OFS_EXT: begin
                            cfg_rdata[CW-1:0]      = pend[i].w;
                            cfg_rdata[Y_LSB +: CW] = pend[i].h;
                        end
                        default: cfg_rdata = '0;
                    endcase
                end
            end
        end
    end

    // R10
    prot_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_we) && $past(cfg_addr) == PROT_ADDR)
        |-> (prot_q == $past(cfg_wdata[NUM_WIN-1:0])));
endmodule

// File: tb/wincfg_bank_tb.sv
module wincfg_bank_tb;
    localparam int NW = 5;
    localparam int CW = 11;
    localparam int AW = 22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vsync = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [NW-1:0]    act_en;
    logic [NW*CW-1:0] act_tl_x, act_tl_y, act_br_x, act_br_y;
    logic [NW*AW-1:0] act_area;

    always #2.5 clk = ~clk;

    wincfg_bank u_dut (
        .clk(clk), .rst(rst), .vsync(vsync), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .act_en(act_en), .act_tl_x(act_tl_x), .act_tl_y(act_tl_y),
        .act_br_x(act_br_x), .act_br_y(act_br_y), .act_area(act_area)
    );

    // reference model
    int p_en[NW], p_x[NW], p_y[NW], p_w[NW], p_h[NW];
    int a_en[NW], a_x[NW], a_y[NW], a_w[NW], a_h[NW];
    int prot;

    typedef struct {
        string tag;
        int    kind;  // 0..5 window fields, 6 read data
        int    win;
        int    exp;
    } item_t;
    item_t sb[$];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    function automatic int last_of(int s, int l);
        return (s + l == 0) ? 0 : s + l - 1;
    endfunction

    function automatic int port_val(int kind, int w);
        case (kind)
            0: return int'(act_en[w]);
            1: return int'(act_tl_x[w*CW +: CW]);
            2: return int'(act_tl_y[w*CW +: CW]);
            3: return int'(act_br_x[w*CW +: CW]);
            4: return int'(act_br_y[w*CW +: CW]);
            5: return int'(act_area[w*AW +: AW]);
            default: return int'(cfg_rdata);
        endcase
    endfunction

    // monitor: pops and compares away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            int got;
            it  = sb.pop_front();
            got = port_val(it.kind, it.win);
            n_tests++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d win=%0d actual=%0d expected=%0d",
                         it.tag, it.kind, it.win, got, it.exp);
            end
        end
    end

    task automatic push(string tag, int kind, int w, int exp);
        item_t it;
        it.tag = tag; it.kind = kind; it.win = w; it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic push_all(string tag);
        for (int w = 0; w < NW; w++) begin
            push(tag, 0, w, a_en[w]);
            push(tag, 1, w, a_x[w]);
            push(tag, 2, w, a_y[w]);
            push(tag, 3, w, last_of(a_x[w], a_w[w]));
            push(tag, 4, w, last_of(a_y[w], a_h[w]));
            push(tag, 5, w, (w <= 2) ? a_w[w] * a_h[w] : 0);
        end
    endtask

    // called just after a posedge; drives one cycle and updates model
    task automatic step(string tag, bit we, int addr, int data, bit vs);
        cfg_we = we; cfg_addr = 8'(addr); cfg_wdata = 32'(data); vsync = vs;
        @(posedge clk); #1;
        if (vs)
            for (int w = 0; w < NW; w++)
                if (!prot[w]) begin
                    a_en[w] = p_en[w]; a_x[w] = p_x[w]; a_y[w] = p_y[w];
                    a_w[w] = p_w[w]; a_h[w] = p_h[w];
                end
        if (we) begin
            if (addr == 'h50) prot = data & 'h1f;
            else if ((addr >> 4) < NW) begin
                int w;
                w = addr >> 4;
                case (addr & 'hf)
                    0: p_en[w] = data & 1;
                    4: begin p_x[w] = data & 'h7ff; p_y[w] = (data >> 16) & 'h7ff; end
                    8: begin p_w[w] = data & 'h7ff; p_h[w] = (data >> 16) & 'h7ff; end
                    default: ;
                endcase
            end
        end
        cfg_we = 0; vsync = 0;
        push_all(tag);
    endtask

    task automatic rd(string tag, int addr, int exp);
        cfg_addr = 8'(addr);
        push(tag, 6, 0, exp);
        @(posedge clk); #1;
    endtask

    function automatic int xy(int x, int y);
        return (y << 16) | x;
    endfunction

    initial begin
        for (int w = 0; w < NW; w++) begin
            p_en[w]=0; p_x[w]=0; p_y[w]=0; p_w[w]=0; p_h[w]=0;
            a_en[w]=0; a_x[w]=0; a_y[w]=0; a_w[w]=0; a_h[w]=0;
        end
        prot = 0;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        push_all("R1");
        @(posedge clk); #1;
        rd("R1", 'h04, 0);
        rd("R1", 'h50, 0);

        // R2 writes reach pending only; R9 map
        step("R2", 1, 'h04, xy(10, 20), 0);
        step("R2", 1, 'h08, xy(100, 50), 0);
        step("R2", 1, 'h00, 1, 0);
        rd("R9", 'h04, xy(10, 20));
        rd("R9", 'h08, xy(100, 50));
        rd("R9", 'h00, 1);
        rd("R9", 'hF0, 0);

        // R3 vsync loads unprotected windows
        step("R3", 0, 0, 0, 1);
        // R7 window 3 has no area
        step("R7", 1, 'h34, xy(5, 6), 0);
        step("R7", 1, 'h38, xy(7, 8), 0);
        step("R7", 1, 'h30, 1, 0);
        step("R7", 0, 0, 0, 1);

        // R4 protect window 0, update windows 0 and 1
        step("R10", 1, 'h50, 'h01, 0);
        rd("R10", 'h50, 'h01);
        step("R4", 1, 'h04, xy(1, 1), 0);
        step("R4", 1, 'h18, xy(20, 30), 0);
        step("R4", 1, 'h10, 1, 0);
        step("R4", 0, 0, 0, 1);
        step("R4", 0, 0, 0, 1);
        step("R4", 1, 'h50, 0, 0);
        step("R4", 0, 0, 0, 1);

        // R5 enable clear waits for vsync
        step("R5", 1, 'h00, 0, 0);
        step("R5", 0, 0, 0, 0);
        step("R5", 0, 0, 0, 1);

        // R6 clamp and inclusive corner
        step("R6", 1, 'h24, xy(0, 3), 0);
        step("R6", 1, 'h28, xy(0, 0), 0);
        step("R6", 0, 0, 0, 1);
        step("R6", 1, 'h28, xy(1, 2), 0);
        step("R6", 0, 0, 0, 1);

        // R8 write coincident with vsync
        step("R8", 1, 'h14, xy(33, 44), 1);
        step("R8", 0, 0, 0, 0);
        step("R8", 0, 0, 0, 1);

        // protect applies to a later vsync (R10), across two windows
        step("R10", 1, 'h50, 'h06, 0);
        step("R10", 1, 'h14, xy(7, 7), 0);
        step("R10", 1, 'h24, xy(9, 9), 0);
        step("R10", 1, 'h04, xy(2, 2), 0);
        step("R10", 0, 0, 0, 1);
        step("R10", 1, 'h50, 0, 1);
        step("R10", 0, 0, 0, 1);

        @(negedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule